// File: doc/BRIEF.md
# Mode-Selectable Event Tag Counter/Timer

This block produces a tag word that travels with every detector event. A small mode code picks how the tag is generated. The tag can be switched off. It can free-run as a timer on the system clock. It can count rising edges seen on an external tag pin. A separate one-bit state pin can also be sampled in some modes and handed out next to the tag. In the counting modes a measurement-start strobe clears the tag. In the timer-with-state mode a tag pulse clears the timer instead.

Both asynchronous pins pass through a synchronizer chain (two flops by default) before use, and only rising edges are counted. The tag wraps modulo 2^TAG_W and never saturates. A wide-word flag tells the event packer that a 64-bit event format is required, with the tag in the upper half. A tag-valid flag tells it whether the tag actually advances.

Top module: `tagtm_top`

## Requirements
- R1: Mode codes 0 and 7 turn everything off. One clock edge after such a code is applied, tag_value is 0 and state_bit is 0. In this state tag_valid and wide_evt are 0, and tag_in, state_in and meas_start have no effect.
- R2: Mode code 1 adds 1 to tag_value on every clock edge, and tag_in and meas_start are ignored. state_bit stays 0.
- R3: Mode code 2 counts rising edges of tag_in. A level that tag_in takes just before clock edge k is seen as an edge and counted at edge k+2. A meas_start that is high at an edge clears the tag to 0, and this clear overrides an edge that is counted at the same edge. state_bit stays 0.
- R4: Mode codes 3 and 4 behave identically. tag_value is held at 0 and tag_in is ignored, but state_bit follows state_in.
- R5: Mode code 5 adds 1 to tag_value on every clock edge. At the edge where a tag_in rising edge is counted (k+2, as in R3), the tag is set to 0 instead. meas_start is ignored and state_bit follows state_in.
- R6: Mode code 6 counts tag_in rising edges with the same latency and the same meas_start clear as R3, and state_bit follows state_in.
- R7: In modes 3, 4, 5 and 6, a state_in level present just before edge k appears on state_bit after edge k+2. In every other mode state_bit is 0.
- R8: wide_evt is 1 exactly for mode codes 1 to 6. tag_valid is 1 exactly for mode codes 1, 2, 5 and 6. Both flags follow mode_code without a register.
- R9: The tag wraps from 2^TAG_W-1 to 0 without saturating.
- R10: While rst_n is low, tag_value and state_bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| meas_start | input | 1 | Synchronous one-cycle strobe that marks the start of a measurement |
| tag_in | input | 1 | Asynchronous external tag pin |
| state_in | input | 1 | Asynchronous state pin |
| mode_code | input | MODE_W (3) | Selects the tag behaviour |
| tag_value | output | TAG_W (32) | Current tag |
| state_bit | output | 1 | Synchronized state level, gated by mode |
| tag_valid | output | 1 | The tag advances in the current mode |
| wide_evt | output | 1 | The event word must use the 64-bit format |

## Verification
tag_value and state_bit change at the clock edge. A tag_in or state_in level driven before edge k shows up after edge k+2, while meas_start acts at edge k itself. The two flags follow mode_code within the same cycle. Inputs are driven just after the falling edge. The bench's own cycle model advances on the rising edge, so it applies the same two-edge delay to the pins and the one-edge delay to meas_start. Every output is compared with that model at the next falling edge. A directed sequence also checks the R3 latency with literal values: 0 at the first two samples and 1 at the third. A second instance with a 4-bit tag is driven in parallel, so the wrap can be seen within a short run.

// File: rtl/tagtm_pkg.sv
package tagtm_pkg;

   // Decoded behaviour of one mode code
   typedef struct packed {
      logic tag_on;     // the tag register is active
      logic use_clk;    // advance on every clock instead of on tag edges
      logic clr_start;  // meas_start clears the tag
      logic clr_pulse;  // a tag rising edge clears the tag
      logic state_on;   // the state pin is sampled
      logic wide;       // the event word uses the wide format
   } tag_cfg_t;

   localparam tag_cfg_t CFG_OFF = '{default: 1'b0};

endpackage

// File: rtl/tagtm_sync.sv
module tagtm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tagtm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/tagtm_mode_dec.sv
module tagtm_mode_dec
   import tagtm_pkg::*;
#(
   parameter int MODE_W = 3
) (
   input  logic [MODE_W-1:0] mode_code,
   output tag_cfg_t          cfg
);

   if (MODE_W < 3) begin : g_bad_mode_w
      $error("tagtm_mode_dec: MODE_W must be at least 3");
   end

   localparam int LAST_MODE = 6;

   always_comb begin
      cfg = CFG_OFF;
      if (int'(mode_code) <= LAST_MODE) begin
         unique case (int'(mode_code))
            1: begin
               cfg.tag_on = 1'b1; cfg.use_clk = 1'b1; cfg.wide = 1'b1;
            end
            2: begin
               cfg.tag_on = 1'b1; cfg.clr_start = 1'b1; cfg.wide = 1'b1;
            end
            3, 4: begin
               cfg.state_on = 1'b1; cfg.wide = 1'b1;
            end
            5: begin
               cfg.tag_on = 1'b1; cfg.use_clk = 1'b1; cfg.clr_pulse = 1'b1;
               cfg.state_on = 1'b1; cfg.wide = 1'b1;
            end
            6: begin
               cfg.tag_on = 1'b1; cfg.clr_start = 1'b1;
               cfg.state_on = 1'b1; cfg.wide = 1'b1;
            end
            default: cfg = CFG_OFF;
         endcase
      end
   end

endmodule

// File: rtl/tagtm_count.sv
module tagtm_count
   import tagtm_pkg::*;
#(
   parameter int TAG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tag_cfg_t         cfg,
   input  logic             meas_start,
   input  logic             tag_lvl,
   output logic [TAG_W-1:0] cnt
);

   if (TAG_W < 2) begin : g_bad_tag_w
      $error("tagtm_count: TAG_W must be at least 2");
   end

   localparam logic [TAG_W-1:0] ONE = TAG_W'(1);

   logic             lvl_prev;
   logic             rise;
   logic [TAG_W-1:0] nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev <= 1'b0;
      else        lvl_prev <= tag_lvl;
   end

   assign rise = tag_lvl & ~lvl_prev;

   always_comb begin
      nxt = cnt;
      if (!cfg.tag_on)
         nxt = '0;
      else if (cfg.use_clk)
         nxt = (cfg.clr_pulse && rise) ? '0 : cnt + ONE;
      else if (cfg.clr_start && meas_start)
         nxt = '0;
      else if (rise)
         nxt = cnt + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= nxt;
   end

   // R1: an inactive tag is held at zero
   p_off_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.tag_on |=> cnt == '0);

   // R2: the plain timer advances by one per clock (R9: wrapping)
   p_timer_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.tag_on && cfg.use_clk && !cfg.clr_pulse) |=> cnt == $past(cnt) + ONE);

   // R3: meas_start clears a counting tag
   p_start_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.tag_on && !cfg.use_clk && meas_start) |=> cnt == '0);

   // R5: a tag edge clears the timer in timer-with-state mode
   p_pulse_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.tag_on && cfg.use_clk && cfg.clr_pulse && rise) |=> cnt == '0);

   // R6: without an edge or a clear, a counting tag holds
   p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.tag_on && !cfg.use_clk && !meas_start && !rise) |=> $stable(cnt));

endmodule

// File: rtl/tagtm_top.sv
module tagtm_top
   import tagtm_pkg::*;
#(
   parameter int TAG_W       = 32,
   parameter int MODE_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              meas_start,
   input  logic              tag_in,
   input  logic              state_in,
   input  logic [MODE_W-1:0] mode_code,
   output logic [TAG_W-1:0]  tag_value,
   output logic              state_bit,
   output logic              tag_valid,
   output logic              wide_evt
);

   tag_cfg_t cfg;
   logic     tag_lvl;
   logic     state_lvl;

   tagtm_mode_dec #(.MODE_W(MODE_W)) u_dec (
      .mode_code (mode_code),
      .cfg       (cfg)
   );

   tagtm_sync #(.STAGES(SYNC_STAGES)) u_sync_tag (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (tag_in),
      .q_sync  (tag_lvl)
   );

   tagtm_sync #(.STAGES(SYNC_STAGES)) u_sync_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (state_in),
      .q_sync  (state_lvl)
   );

   tagtm_count #(.TAG_W(TAG_W)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg        (cfg),
      .meas_start (meas_start),
      .tag_lvl    (tag_lvl),
      .cnt        (tag_value)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_bit <= 1'b0;
      else        state_bit <= cfg.state_on & state_lvl;
   end

   assign tag_valid = cfg.tag_on;
   assign wide_evt  = cfg.wide;

   // R7: the state bit is quiet in modes that do not sample the state pin
   p_state_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.state_on |=> !state_bit);

   // R8: an advancing tag always needs the wide event word
   always_comb begin
      p_valid_wide_r8: assert (!tag_valid || wide_evt);
   end

endmodule

// File: tb/tagtm_top_test.sv
module tagtm_top_test;

   localparam int CLK_PERIOD = 10;
   localparam int NARROW_W   = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        meas_start = 1'b0;
   logic        tag_in = 1'b0;
   logic        state_in = 1'b0;
   logic [2:0]  mode_code = 3'd0;
   logic [31:0] tag_value;
   logic        state_bit, tag_valid, wide_evt;
   logic [NARROW_W-1:0] n_tag;
   logic        n_state, n_valid, n_wide;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tagtm_top uut (
      .clk(clk), .rst_n(rst_n), .meas_start(meas_start), .tag_in(tag_in),
      .state_in(state_in), .mode_code(mode_code), .tag_value(tag_value),
      .state_bit(state_bit), .tag_valid(tag_valid), .wide_evt(wide_evt)
   );

   tagtm_top #(.TAG_W(NARROW_W)) uut_narrow (
      .clk(clk), .rst_n(rst_n), .meas_start(meas_start), .tag_in(tag_in),
      .state_in(state_in), .mode_code(mode_code), .tag_value(n_tag),
      .state_bit(n_state), .tag_valid(n_valid), .wide_evt(n_wide)
   );

   // Cycle model built from the requirements
   logic        m_t1, m_t2, m_tp, m_s1, m_s2, m_st, m_rise;
   logic [31:0] m_tag;

   function automatic bit state_mode(input logic [2:0] m);
      return (m >= 3'd3) && (m <= 3'd6);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {m_t1, m_t2, m_tp, m_s1, m_s2, m_st} = '0;
         m_tag = '0;
      end else begin
         m_rise = m_t2 & ~m_tp;
         m_tp = m_t2; m_t2 = m_t1; m_t1 = tag_in;
         m_st = state_mode(mode_code) ? m_s2 : 1'b0;
         m_s2 = m_s1; m_s1 = state_in;
         case (mode_code)
            3'd1:       m_tag = m_tag + 1;
            3'd2, 3'd6: if (meas_start) m_tag = '0;
                        else if (m_rise) m_tag = m_tag + 1;
            3'd5:       m_tag = m_rise ? 32'd0 : m_tag + 1;
            default:    m_tag = '0;
         endcase
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d (mode %0d, t=%0t)",
                  req, act, exp, mode_code, $time);
      end
   endtask

   function automatic string tag_req(input logic [2:0] m);
      case (m)
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3, 3'd4: return "R4";
         3'd5: return "R5";
         3'd6: return "R6";
         default: return "R1";
      endcase
   endfunction

   task automatic check_all();
      bit exp_valid, exp_wide;
      exp_valid = (mode_code == 3'd1) || (mode_code == 3'd2) ||
                  (mode_code == 3'd5) || (mode_code == 3'd6);
      exp_wide  = (mode_code >= 3'd1) && (mode_code <= 3'd6);
      check(tag_req(mode_code), tag_value, m_tag);
      check("R9 narrow wrap", n_tag, m_tag[NARROW_W-1:0]);
      check("R7 state", state_bit, m_st);
      check("R7 state narrow", n_state, m_st);
      check("R8 tag_valid", tag_valid, exp_valid);
      check("R8 wide_evt", wide_evt, exp_wide);
      check("R8 narrow flags", {n_valid, n_wide}, {exp_valid, exp_wide});
   endtask

   // One cycle: sample at falling edge, then drive new inputs
   task automatic run_random(input int cycles, input int start_pct);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         check_all();
         tag_in     = ($urandom % 3) == 0 ? ~tag_in : tag_in;
         state_in   = $urandom % 2;
         meas_start = ($urandom % 100) < start_pct;
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      // R10: reset state
      repeat (3) @(negedge clk);
      mode_code = 3'd1;
      tag_in = 1'b1; state_in = 1'b1;
      @(negedge clk);
      check("R10 reset tag", tag_value, 0);
      check("R10 reset state", state_bit, 0);
      tag_in = 1'b0; state_in = 1'b0; mode_code = 3'd0;
      rst_n = 1'b1;
      @(negedge clk);

      // R3: directed latency, from a cleared count
      mode_code = 3'd2; meas_start = 1'b1;
      @(negedge clk);
      meas_start = 1'b0;
      repeat (3) @(negedge clk);
      check("R3 cleared", tag_value, 0);
      tag_in = 1'b1;
      @(negedge clk); check("R3 latency 1", tag_value, 0);
      @(negedge clk); check("R3 latency 2", tag_value, 0);
      @(negedge clk); check("R3 latency 3", tag_value, 1);
      repeat (3) @(negedge clk);
      check("R3 level holds", tag_value, 1);
      tag_in = 1'b0;

      // Random traffic in every mode code, including 7 (R1)
      for (int r = 0; r < 3; r++) begin
         for (int m = 0; m < 8; m++) begin
            mode_code = 3'(m);
            run_random(60, (m == 2 || m == 6) ? 5 : 10);
         end
      end

      // R5: tag edges clear the timer while it runs
      mode_code = 3'd5;
      run_random(200, 20);
      // R9: long timer run wraps the narrow instance many times
      mode_code = 3'd1;
      run_random(100, 50);

      // R10: reset in the middle of counting
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R10 async reset tag", tag_value, 0);
      check("R10 async reset state", state_bit, 0);
      @(negedge clk);
      rst_n = 1'b1;
      mode_code = 3'd6;
      run_random(100, 5);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule